// File: doc/BRIEF.md
# Question-Answer Windowed Watchdog

This block is a challenge-response watchdog. The host may read an 8-bit question, derive four answer bytes from it and write them one by one to the answer port. A pass needs the right bytes in the right order. Bytes 3, 2 and 1 must land in the first half of the watchdog period and byte 0 in the second half. The two halves are called window 1 and window 2.

After a good cycle, the question moves to its next value and the error count goes back to zero. A wrong, out-of-order, early or missing byte fails the cycle. A failed cycle leaves the question as it was and adds one to the error count. When the count reaches a programmed threshold, a failure flag rises and stays high until reset.

Any answer write in window 2 ends the cycle at once and starts a fresh window 1. Reading the question restarts window 1 if no byte has been accepted yet in the current cycle. Reads made after that point have no effect.

Top module: `qa_watchdog`

## Requirements
- R1: After reset, `question_o` is 8'h01, `err_cnt_o` is 0, `fail_o` is 0 and `in_window2_o` is 0 (window 1).
- R2: Each window lasts floor(`period_i`/2) clock cycles, counted from the cycle after the window starts. `in_window2_o` is 1 during window 2 only.
- R3: The expected answer byte for index i is ((question XOR 8'hA5) + i) mod 256. Bytes must arrive in index order 3, 2, 1 inside window 1, and byte 0 inside window 2.
- R4: A fully correct cycle advances the question as a 4-bit shift register. The next value is {q[2:0], q[3]^q[2]}, zero-extended to 8 bits. The same cycle clears `err_cnt_o` to 0 and starts a new window 1 on the next cycle.
- R5: Any answer write during window 2 ends the cycle in that clock. A new window 1 follows immediately.
- R6: A bad cycle leaves `question_o` unchanged and raises `err_cnt_o` by one. The count saturates at its maximum value.
- R7: If window 2 ends with no answer write, the cycle is judged bad in its last cycle.
- R8: Any of the following in window 1 makes the cycle bad: a wrong byte, a fourth write, or fewer than three correct bytes by the end of window 1.
- R9: A question read restarts window 1 from its first cycle only while no answer byte has been taken in the current cycle. Otherwise it has no effect on timing or evaluation.
- R10: `fail_o` rises once `err_cnt_o` reaches `err_thresh_i`. It stays high until reset, including across later good cycles.
- R11: A write in the last cycle of a window counts as part of that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_rd_i | input | 1 | Question read strobe |
| ans_wr_i | input | 1 | Answer write strobe |
| ans_data_i | input | 8 | Answer byte |
| period_i | input | PERIOD_W | Total watchdog period in cycles |
| err_thresh_i | input | ERR_W | Error count at which failure is raised |
| question_o | output | 8 | Current question |
| err_cnt_o | output | ERR_W | Error counter |
| fail_o | output | 1 | Sticky failure flag |
| in_window2_o | output | 1 | High while window 2 is open |

## Verification
Two functions can fall in the same clock: an answer write and the last cycle of a window. The bench times byte 1 into the final cycle of window 1 and expects it to be accepted. It also writes byte 0 in the final cycle of window 2 and expects a good cycle rather than an expiry. A second pairing is a question read in the same cycle as window bookkeeping after answers have begun. The bench shows that interleaved reads leave the window 2 timing unchanged: the final byte is accepted at the moment predicted by the first read alone.

// File: rtl/qa_wd_pkg.sv
package qa_wd_pkg;
  localparam int QW  = 8;
  localparam int LW  = 4;
  localparam logic [QW-1:0] ANS_KEY = 8'hA5;
  localparam logic [LW-1:0] LFSR_SEED = 4'h1;

  typedef enum logic {WIN_FIRST = 1'b0, WIN_SECOND = 1'b1} win_e;

  function automatic logic [QW-1:0] qa_expect(input logic [QW-1:0] q, input logic [1:0] idx);
    return (q ^ ANS_KEY) + {{(QW-2){1'b0}}, idx};
  endfunction

  function automatic logic [LW-1:0] lfsr_step(input logic [LW-1:0] s);
    return {s[LW-2:0], s[LW-1] ^ s[LW-2]};
  endfunction
endpackage

// File: rtl/qa_win_timer.sv
module qa_win_timer
  import qa_wd_pkg::*;
#(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                restart_i,
  output win_e                win_o,
  output logic                last_o
);
  logic [PERIOD_W-1:0] tmr_q;
  logic [PERIOD_W-1:0] half_len;
  logic [PERIOD_W-1:0] half_m1;
  win_e                win_q;

  always_comb begin
    half_len = period_i >> 1;
    half_m1  = (half_len == '0) ? '0 : half_len - 1'b1;
  end

  assign last_o = (tmr_q >= half_m1);
  assign win_o  = win_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      tmr_q <= '0;
      win_q <= WIN_FIRST;
    end else if (last_o) begin
      tmr_q <= '0;
      win_q <= (win_q == WIN_FIRST) ? WIN_SECOND : WIN_FIRST;
    end else begin
      tmr_q <= tmr_q + 1'b1;
    end
  end

  // R2: a window does not change before its count runs out
  p_win_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!restart_i && !last_o) |=> (win_q == $past(win_q)));
endmodule

// File: rtl/qa_ans_seq.sv
module qa_ans_seq
  import qa_wd_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  win_e          win_i,
  input  logic          win_last_i,
  input  logic          restart_i,
  input  logic          ans_wr_i,
  input  logic [QW-1:0] ans_data_i,
  input  logic [QW-1:0] question_i,
  output logic          fresh_o,
  output logic          cycle_end_o,
  output logic          good_o
);
  logic [1:0]    idx_q, idx_n;
  logic          bad_q, bad_n;
  logic [QW-1:0] exp_byte;

  assign fresh_o = (win_i == WIN_FIRST) && (idx_q == 2'd3) && !bad_q;

  always_comb begin
    idx_n       = idx_q;
    bad_n       = bad_q;
    cycle_end_o = 1'b0;
    good_o      = 1'b0;
    exp_byte    = qa_expect(question_i, idx_q);
    if (win_i == WIN_FIRST) begin
      if (ans_wr_i) begin
        if (idx_q != 2'd0 && ans_data_i == exp_byte) idx_n = idx_q - 2'd1;
        else                                         bad_n = 1'b1;
      end
      if (win_last_i && idx_n != 2'd0) bad_n = 1'b1;
    end else begin
      if (ans_wr_i) begin
        cycle_end_o = 1'b1;
        good_o      = (idx_q == 2'd0) && !bad_q && (ans_data_i == exp_byte);
      end else if (win_last_i) begin
        cycle_end_o = 1'b1;
      end
    end
    if (cycle_end_o || restart_i) begin
      idx_n = 2'd3;
      bad_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= 2'd3;
      bad_q <= 1'b0;
    end else begin
      idx_q <= idx_n;
      bad_q <= bad_n;
    end
  end

  // R3: the answer index only steps down by one or reloads to 3
  p_idx_step_r3: assert property (@(posedge clk) disable iff (rst)
    (idx_q != $past(idx_q)) |-> ((idx_q == $past(idx_q) - 2'd1) || (idx_q == 2'd3)));
endmodule

// File: rtl/qa_question_gen.sv
module qa_question_gen
  import qa_wd_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          advance_i,
  output logic [QW-1:0] question_o
);
  logic [LW-1:0] lfsr_q;

  always_ff @(posedge clk) begin
    if (rst)            lfsr_q <= LFSR_SEED;
    else if (advance_i) lfsr_q <= lfsr_step(lfsr_q);
  end

  assign question_o = {{(QW-LW){1'b0}}, lfsr_q};
endmodule

// File: rtl/qa_watchdog.sv
module qa_watchdog
  import qa_wd_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int ERR_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                q_rd_i,
  input  logic                ans_wr_i,
  input  logic [7:0]          ans_data_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [ERR_W-1:0]    err_thresh_i,
  output logic [7:0]          question_o,
  output logic [ERR_W-1:0]    err_cnt_o,
  output logic                fail_o,
  output logic                in_window2_o
);
  win_e             win;
  logic             win_last;
  logic             fresh, cycle_end, good, restart_rd, restart;
  logic [ERR_W-1:0] err_inc;

  assign restart_rd = q_rd_i && !ans_wr_i && fresh;
  assign restart    = restart_rd || cycle_end;

  qa_win_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk(clk), .rst(rst), .period_i(period_i), .restart_i(restart),
    .win_o(win), .last_o(win_last));

  qa_ans_seq u_seq (
    .clk(clk), .rst(rst), .win_i(win), .win_last_i(win_last),
    .restart_i(restart_rd), .ans_wr_i(ans_wr_i), .ans_data_i(ans_data_i),
    .question_i(question_o), .fresh_o(fresh), .cycle_end_o(cycle_end),
    .good_o(good));

  qa_question_gen u_qgen (
    .clk(clk), .rst(rst), .advance_i(good), .question_o(question_o));

  assign err_inc      = (err_cnt_o == '1) ? err_cnt_o : err_cnt_o + 1'b1;
  assign in_window2_o = (win == WIN_SECOND);

  always_ff @(posedge clk) begin
    if (rst) begin
      err_cnt_o <= '0;
      fail_o    <= 1'b0;
    end else if (good) begin
      err_cnt_o <= '0;
    end else if (cycle_end) begin
      err_cnt_o <= err_inc;
      if (err_inc >= err_thresh_i) fail_o <= 1'b1;
    end
  end

  // R6: a failed cycle keeps the question
  p_q_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (cycle_end && !good) |=> $stable(question_o));
  // R4: a good cycle clears errors and changes the question
  p_good_clear_r4: assert property (@(posedge clk) disable iff (rst)
    good |=> (err_cnt_o == '0 && question_o != $past(question_o)));
  // R10: failure is sticky
  p_fail_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    fail_o |=> fail_o);
  // R5: a finished cycle reopens window 1
  p_end_win1_r5: assert property (@(posedge clk) disable iff (rst)
    cycle_end |=> !in_window2_o);
endmodule

// File: tb/qa_watchdog_tb_top.sv
module qa_watchdog_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       q_rd, ans_wr;
  logic [7:0] ans_data;
  logic [15:0] period;
  logic [3:0] thresh;
  logic [7:0] question;
  logic [3:0] err_cnt;
  logic       fail, in_w2;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;
  logic [7:0] q_m;
  int err_m;

  always #4 clk = ~clk;

  qa_watchdog #(.PERIOD_W(16), .ERR_W(4)) dut_i (
    .clk(clk), .rst(rst), .q_rd_i(q_rd), .ans_wr_i(ans_wr), .ans_data_i(ans_data),
    .period_i(period), .err_thresh_i(thresh), .question_o(question),
    .err_cnt_o(err_cnt), .fail_o(fail), .in_window2_o(in_w2));

  function automatic logic [7:0] ans(input logic [7:0] q, input int i);
    return (q ^ 8'hA5) + 8'(i);
  endfunction

  function automatic logic [7:0] nxt(input logic [7:0] q);
    return {4'h0, q[2:0], q[3] ^ q[2]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic edge1(input bit rd, input bit wr, input logic [7:0] d);
    q_rd = rd; ans_wr = wr; ans_data = d;
    @(negedge clk);
    q_rd = 1'b0; ans_wr = 1'b0; ans_data = 8'h00;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) edge1(1'b0, 1'b0, 8'h00);
  endtask

  task automatic chk_state(input string req);
    chk(question == q_m, req, "question", question, q_m);
    chk(err_cnt == err_m[3:0], req, "err_cnt", err_cnt, err_m);
  endtask

  task automatic three_early();
    edge1(1'b0, 1'b1, ans(q_m, 3));
    edge1(1'b0, 1'b1, ans(q_m, 2));
    edge1(1'b0, 1'b1, ans(q_m, 1));
  endtask

  task automatic t_reset();
    chk(question == 8'h01, "R1", "question", question, 1);
    chk(err_cnt == 0, "R1", "err_cnt", err_cnt, 0);
    chk(fail == 0, "R1", "fail", fail, 0);
    chk(in_w2 == 0, "R1", "window", in_w2, 0);
  endtask

  task automatic t_good_read();
    edge1(1'b1, 1'b0, 8'h00);           // R
    three_early();                       // R+1..R+3
    idle(16);                            // R+4..R+19
    chk(in_w2 == 0, "R2", "still window1", in_w2, 0);
    idle(1);                             // R+20
    chk(in_w2 == 1, "R2", "window2 open", in_w2, 1);
    edge1(1'b0, 1'b1, ans(q_m, 0));      // R+21
    q_m = nxt(q_m); err_m = 0;
    chk_state("R4");
    chk(in_w2 == 0, "R4", "new window1", in_w2, 0);
  endtask

  task automatic t_no_read_late();
    idle(14);
    three_early();                       // X+15..X+17
    idle(3);
    edge1(1'b0, 1'b1, ans(q_m, 0));      // X+21
    q_m = nxt(q_m); err_m = 0;
    chk_state("R3");
  endtask

  task automatic t_wrong_byte();
    edge1(1'b1, 1'b0, 8'h00);
    edge1(1'b0, 1'b1, ans(q_m, 3) ^ 8'h01);
    edge1(1'b0, 1'b1, ans(q_m, 2));
    edge1(1'b0, 1'b1, ans(q_m, 1));
    idle(17);
    chk(in_w2 == 1, "R5", "window2 before write", in_w2, 1);
    edge1(1'b0, 1'b1, ans(q_m, 0));
    err_m++;
    chk_state("R6");
    chk(in_w2 == 0, "R5", "write ends window2", in_w2, 0);
  endtask

  task automatic t_missing();
    edge1(1'b1, 1'b0, 8'h00);
    three_early();
    idle(36);                            // R+4..R+39
    chk(err_cnt == err_m[3:0], "R7", "no error before expiry", err_cnt, err_m);
    idle(1);                             // R+40
    err_m++;
    chk_state("R7");
  endtask

  task automatic t_early_final();
    edge1(1'b1, 1'b0, 8'h00);
    three_early();
    edge1(1'b0, 1'b1, ans(q_m, 0));      // R+4, fourth write in window1
    chk(question == q_m, "R8", "no early advance", question, q_m);
    idle(16);
    edge1(1'b0, 1'b1, ans(q_m, 0));      // R+21
    err_m++;
    chk_state("R8");
    chk(fail == 0, "R10", "below threshold", fail, 0);
  endtask

  task automatic t_threshold();
    edge1(1'b1, 1'b0, 8'h00);
    idle(40);                            // nothing written
    err_m++;
    chk_state("R8");
    chk(fail == 1, "R10", "fail at threshold", fail, 1);
  endtask

  task automatic t_sticky();
    edge1(1'b1, 1'b0, 8'h00);
    three_early();
    idle(17);
    edge1(1'b0, 1'b1, ans(q_m, 0));
    q_m = nxt(q_m); err_m = 0;
    chk_state("R4");
    chk(fail == 1, "R10", "fail sticky", fail, 1);
  endtask

  task automatic t_reread_restart();
    edge1(1'b1, 1'b0, 8'h00);            // R
    idle(14);                            // R+1..R+14
    edge1(1'b1, 1'b0, 8'h00);            // R+15, restart
    idle(6);                             // R+16..R+21
    chk(in_w2 == 0, "R9", "restarted window1", in_w2, 0);
    idle(8);                             // R+22..R+29
    three_early();                       // R+30..R+32
    idle(3);                             // R+33..R+35
    chk(in_w2 == 1, "R9", "window2 after restart", in_w2, 1);
    edge1(1'b0, 1'b1, ans(q_m, 0));      // R+36
    q_m = nxt(q_m); err_m = 0;
    chk_state("R9");
  endtask

  task automatic t_interleave();
    edge1(1'b1, 1'b0, 8'h00);            // R
    edge1(1'b0, 1'b1, ans(q_m, 3));      // R+1
    edge1(1'b1, 1'b0, 8'h00);            // R+2
    edge1(1'b0, 1'b1, ans(q_m, 2));      // R+3
    edge1(1'b1, 1'b0, 8'h00);            // R+4
    edge1(1'b0, 1'b1, ans(q_m, 1));      // R+5
    idle(15);                            // R+6..R+20
    edge1(1'b0, 1'b1, ans(q_m, 0));      // R+21
    q_m = nxt(q_m); err_m = 0;
    chk_state("R9");
  endtask

  task automatic t_boundary_w1();
    edge1(1'b1, 1'b0, 8'h00);            // R
    idle(17);                            // R+1..R+17
    edge1(1'b0, 1'b1, ans(q_m, 3));      // R+18
    edge1(1'b0, 1'b1, ans(q_m, 2));      // R+19
    edge1(1'b0, 1'b1, ans(q_m, 1));      // R+20 last cycle of window1
    chk(in_w2 == 1, "R11", "window2 after last w1 write", in_w2, 1);
    edge1(1'b0, 1'b1, ans(q_m, 0));      // R+21
    q_m = nxt(q_m); err_m = 0;
    chk_state("R11");
  endtask

  task automatic t_boundary_w2();
    edge1(1'b1, 1'b0, 8'h00);
    three_early();
    idle(36);                            // R+4..R+39
    edge1(1'b0, 1'b1, ans(q_m, 0));      // R+40 last cycle of window2
    q_m = nxt(q_m); err_m = 0;
    chk_state("R11");
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    rst = 1'b1; q_rd = 0; ans_wr = 0; ans_data = 0;
    period = 16'd40; thresh = 4'd4;
    q_m = 8'h01; err_m = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_good_read();
    t_no_read_late();
    t_wrong_byte();
    t_missing();
    t_early_final();
    t_threshold();
    t_sticky();
    t_reread_restart();
    t_interleave();
    t_boundary_w1();
    t_boundary_w2();
    finished = 1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
    end
  end
endmodule